// File: doc/BRIEF.md
# Cellular-Automaton Keyed Pixel Encryptor

This engine scrambles a square 8-bit grayscale image, one pixel at a time. It reads each pixel from an on-chip source memory and writes the ciphertext byte to the same address of an on-chip destination memory. In the default keyed mode, an eight-cell hybrid rule-90/rule-150 cellular automaton produces a fresh key for every pixel. The key is combined with the pixel by XOR on even pixels and by XNOR on odd pixels. That combined byte is then multiplied by the pixel in GF(2^8).

A second mode keeps one constant key for the whole image. In that mode every pixel is simply multiplied by the key, which saves one cycle per pixel.

Software or a sequencer loads a seed (or a constant key), selects the mode and pulses `start`. It then waits for the one-cycle `done` pulse. The source memory is a synchronous read port: data appears one cycle after the read enable.

Top module: `pix_encryptor`

## Requirements
- R1: After reset `busy`, `done`, `srcRe` and `dstWe` are all low.
- R2: In keyed mode the automaton holds 8 cells. Cells 2, 4 and 6 follow rule 150 (left XOR self XOR right), and all other cells follow rule 90 (left XOR right). A neighbour outside the array reads as 0. The automaton advances exactly once per pixel, before that pixel is read, so pixel 0 uses the state one step past the loaded seed.
- R3: In keyed mode a seed of 0x00 is loaded as 0x01.
- R4: In keyed mode the key is XORed with the pixel on even pixel indices and XNORed on odd indices, starting with XOR at pixel 0 of every run.
- R5: Each output byte is the GF(2^8) product, modulo x^8+x^4+x^3+x+1, of the pixel and either the mixed key (keyed mode) or the constant key given on `keySeed` (fixed mode, `fixedMode`=1, used unchanged). For example, 0x23 times 0xAA gives 0x79.
- R6: Writes go to addresses 0 up to N-1 in rising order, one write per pixel, where N is IMG_SIDE squared.
- R7: In keyed mode `busy` is high for exactly 4N cycles, starting in the cycle after `start` is sampled.
- R8: In fixed mode `busy` is high for exactly 3N cycles.
- R9: `done` is high for exactly one cycle, the cycle right after the final write, and `busy` is low in that cycle.
- R10: A `start` pulse while a run is in progress is ignored: outputs, mode, key and timing are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| fixedMode | input | 1 | 1 = constant key, 0 = automaton key; sampled with start |
| keySeed | input | 8 | Automaton seed or constant key; sampled with start |
| srcRe | output | 1 | Source memory read enable |
| srcAddr | output | ADDR_W | Source memory address |
| srcData | input | 8 | Source read data, valid the cycle after srcRe |
| dstWe | output | 1 | Destination memory write enable |
| dstAddr | output | ADDR_W | Destination memory address |
| dstData | output | 8 | Encrypted pixel |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach is a `start` pulse that arrives partway through a run, especially one carrying a different mode and a zero seed. If that pulse were accepted it would silently reseed the automaton and reset the XOR/XNOR phase. The bench injects such a pulse ten cycles into a keyed run. It then compares every ciphertext byte and the busy length against a model of the undisturbed run. Zero-seed substitution is reached with a uniform image, so that every difference between output bytes comes only from the key sequence and the alternating mix.

// File: rtl/pix_enc_pkg.sv
package pix_enc_pkg;
  localparam int PIX_W = 8;
  localparam logic [PIX_W-1:0] GF_REDUCE = 8'h1B;  // low byte of x^8+x^4+x^3+x+1

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_MIX, ST_MUL, ST_WRITE, ST_DONE
  } encState_t;

  typedef struct packed {
    logic load;     // accept a new run
    logic caStep;   // advance automaton
    logic mixEn;    // capture mixed key and pixel
    logic mulEn;    // capture product
    logic advance;  // pixel written, flip mix phase
  } encCtrl_t;

  function automatic logic [PIX_W-1:0] gfMul(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b);
    logic [PIX_W-1:0] acc;
    acc = '0;
    for (int i = PIX_W - 1; i >= 0; i--) begin
      acc = {acc[PIX_W-2:0], 1'b0} ^ (acc[PIX_W-1] ? GF_REDUCE : '0) ^ (b[i] ? a : '0);
    end
    return acc;
  endfunction
endpackage

// File: rtl/pix_enc_datapath.sv
module pix_enc_datapath
  import pix_enc_pkg::*;
#(
  parameter logic [PIX_W-1:0] RULE150_MASK = 8'h54
) (
  input  logic             clk,
  input  logic             rstN,
  input  encCtrl_t         ctrl,
  input  logic             fixedMode,
  input  logic             modeFixed,
  input  logic [PIX_W-1:0] keySeed,
  input  logic [PIX_W-1:0] srcData,
  output logic [PIX_W-1:0] product
);
  logic [PIX_W-1:0] caState;
  logic [PIX_W-1:0] caNext;
  logic [PIX_W-1:0] mixedKey;
  logic [PIX_W-1:0] pixReg;
  logic             xnorPhase;

  for (genvar c = 0; c < PIX_W; c++) begin : g_cell
    logic lft;
    logic rgt;
    if (c == 0) begin : g_lEdge
      assign lft = 1'b0;
    end else begin : g_lIn
      assign lft = caState[c-1];
    end
    if (c == PIX_W - 1) begin : g_rEdge
      assign rgt = 1'b0;
    end else begin : g_rIn
      assign rgt = caState[c+1];
    end
    if (RULE150_MASK[c]) begin : g_r150
      assign caNext[c] = lft ^ caState[c] ^ rgt;
    end else begin : g_r90
      assign caNext[c] = lft ^ rgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      caState   <= '0;
      mixedKey  <= '0;
      pixReg    <= '0;
      product   <= '0;
      xnorPhase <= 1'b0;
    end else begin
      if (ctrl.load) begin
        caState   <= (!fixedMode && keySeed == '0) ? PIX_W'(1) : keySeed;
        xnorPhase <= 1'b0;
      end else begin
        if (ctrl.caStep) caState <= caNext;
        if (ctrl.advance) xnorPhase <= ~xnorPhase;
      end
      if (ctrl.mixEn) begin
        mixedKey <= xnorPhase ? ~(caState ^ srcData) : (caState ^ srcData);
        pixReg   <= srcData;
      end
      if (ctrl.mulEn) begin
        product <= modeFixed ? gfMul(caState, srcData) : gfMul(mixedKey, pixReg);
      end
    end
  end
endmodule

// File: rtl/pix_enc_control.sv
module pix_enc_control
  import pix_enc_pkg::*;
#(
  parameter int IMG_PIXELS = 16384,
  parameter int ADDR_W     = $clog2(IMG_PIXELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              fixedMode,
  output encCtrl_t          ctrl,
  output logic              modeFixed,
  output logic              srcRe,
  output logic              dstWe,
  output logic [ADDR_W-1:0] pixIdx,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(IMG_PIXELS - 1);

  encState_t state;
  encState_t stateNext;

  always_comb begin
    ctrl      = '0;
    srcRe     = 1'b0;
    dstWe     = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctrl.load = 1'b1;
        stateNext = ST_FETCH;
      end
      ST_FETCH: begin
        srcRe       = 1'b1;
        ctrl.caStep = !modeFixed;
        stateNext   = modeFixed ? ST_MUL : ST_MIX;
      end
      ST_MIX: begin
        ctrl.mixEn = 1'b1;
        stateNext  = ST_MUL;
      end
      ST_MUL: begin
        ctrl.mulEn = 1'b1;
        stateNext  = ST_WRITE;
      end
      ST_WRITE: begin
        dstWe        = 1'b1;
        ctrl.advance = 1'b1;
        stateNext    = (pixIdx == LAST_IDX) ? ST_DONE : ST_FETCH;
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pixIdx    <= '0;
      modeFixed <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctrl.load) begin
        pixIdx    <= '0;
        modeFixed <= fixedMode;
      end else if (dstWe && pixIdx != LAST_IDX) begin
        pixIdx <= pixIdx + 1'b1;
      end
    end
  end

  assign busy = (state == ST_FETCH) || (state == ST_MIX) ||
                (state == ST_MUL) || (state == ST_WRITE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/pix_encryptor.sv
module pix_encryptor
  import pix_enc_pkg::*;
#(
  parameter int IMG_SIDE = 128,
  parameter int ADDR_W   = $clog2(IMG_SIDE * IMG_SIDE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              fixedMode,
  input  logic [7:0]        keySeed,
  output logic              srcRe,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [7:0]        srcData,
  output logic              dstWe,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [7:0]        dstData,
  output logic              busy,
  output logic              done
);
  localparam int IMG_PIXELS = IMG_SIDE * IMG_SIDE;

  encCtrl_t          ctrl;
  logic              modeFixed;
  logic [ADDR_W-1:0] pixIdx;

  pix_enc_control #(.IMG_PIXELS(IMG_PIXELS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .fixedMode(fixedMode),
    .ctrl(ctrl), .modeFixed(modeFixed), .srcRe(srcRe), .dstWe(dstWe),
    .pixIdx(pixIdx), .busy(busy), .done(done)
  );

  pix_enc_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .fixedMode(fixedMode),
    .modeFixed(modeFixed), .keySeed(keySeed), .srcData(srcData),
    .product(dstData)
  );

  assign srcAddr = pixIdx;
  assign dstAddr = pixIdx;
endmodule

// File: rtl/pix_encryptor_checker.sv
module pix_encryptor_checker (
  input logic clk,
  input logic rstN,
  input logic srcRe,
  input logic dstWe,
  input logic busy,
  input logic done
);
  assert_no_busy_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(dstWe));
  assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));
  assert_write_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    dstWe |=> !dstWe);
  assert_access_in_run_R1: assert property (@(posedge clk) disable iff (!rstN)
    (srcRe || dstWe) |-> busy);
endmodule

bind pix_encryptor pix_encryptor_checker u_chk (
  .clk(clk), .rstN(rstN), .srcRe(srcRe), .dstWe(dstWe), .busy(busy), .done(done)
);

// File: tb/pix_encryptor_tb.sv
module pix_encryptor_tb;
  localparam int SIDE = 4;
  localparam int NPIX = SIDE * SIDE;
  localparam int AW   = $clog2(NPIX);
  // pixel, key, product
  localparam logic [23:0] VEC [8] = '{
    {8'h23, 8'hAA, 8'h79}, {8'h5F, 8'hAA, 8'h31}, {8'hB7, 8'hAA, 8'hEF},
    {8'hFF, 8'hAA, 8'hEB}, {8'h53, 8'hCA, 8'h01}, {8'h02, 8'h80, 8'h1B},
    {8'h01, 8'hC3, 8'hC3}, {8'h00, 8'h7E, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic fixedMode = 1'b0;
  logic [7:0] keySeed = 8'h00;
  logic srcRe, dstWe, busy, done;
  logic [AW-1:0] srcAddr, dstAddr;
  logic [7:0] srcData, dstData;
  logic [7:0] srcMem [NPIX];
  logic [7:0] dstMem [NPIX];
  logic clearLog = 1'b0;
  int wrCount;
  logic orderBad;
  int checks = 0;
  int fails = 0;
  int busyCnt, doneCnt, lastWr, doneAt;
  logic riseOk, overlap;

  always #4 clk = ~clk;

  pix_encryptor #(.IMG_SIDE(SIDE)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .fixedMode(fixedMode), .keySeed(keySeed),
    .srcRe(srcRe), .srcAddr(srcAddr), .srcData(srcData),
    .dstWe(dstWe), .dstAddr(dstAddr), .dstData(dstData), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (srcRe) srcData <= srcMem[srcAddr];
  end

  always @(posedge clk) begin
    if (clearLog) begin
      wrCount  <= 0;
      orderBad <= 1'b0;
    end else if (dstWe) begin
      dstMem[dstAddr] <= dstData;
      if (int'(dstAddr) != wrCount) orderBad <= 1'b1;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mGf(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] mStep(input logic [7:0] s);
    return (s << 1) ^ (s >> 1) ^ (s & 8'h54);
  endfunction

  task automatic runImage(input bit fm, input logic [7:0] seed, input bit inject);
    int cyc;
    @(negedge clk);
    clearLog = 1'b1;
    fixedMode = fm; keySeed = seed; start = 1'b1;
    @(negedge clk);
    clearLog = 1'b0;
    start = 1'b0;
    riseOk = busy; busyCnt = busy ? 1 : 0;
    doneCnt = 0; lastWr = -10; doneAt = -1; overlap = 1'b0; cyc = 0;
    while (cyc < 4000 && (doneAt < 0 || cyc < doneAt + 3)) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 10) begin
        start = 1'b1; fixedMode = ~fm; keySeed = 8'h00;
      end else if (inject && cyc == 11) begin
        start = 1'b0; fixedMode = fm; keySeed = seed;
      end
      if (busy) busyCnt++;
      if (dstWe) lastWr = cyc;
      if (done) begin
        doneCnt++;
        if (doneAt < 0) doneAt = cyc;
        if (busy) overlap = 1'b1;
      end
    end
    check(doneAt >= 0, "watchdog run end", doneAt, 1);
  endtask

  task automatic checkKeyed(input logic [7:0] seed, input string tag);
    logic [7:0] k = (seed == 8'h00) ? 8'h01 : seed;
    int bad = 0;
    logic [7:0] firstGot = 8'h00, firstExp = 8'h00;
    for (int p = 0; p < NPIX; p++) begin
      logic [7:0] m;
      logic [7:0] e;
      k = mStep(k);
      m = (p % 2 == 1) ? ~(k ^ srcMem[p]) : (k ^ srcMem[p]);
      e = mGf(m, srcMem[p]);
      if (dstMem[p] !== e && bad == 0) begin firstGot = dstMem[p]; firstExp = e; end
      if (dstMem[p] !== e) bad++;
    end
    check(bad == 0, tag, firstGot, firstExp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPIX; i++) srcMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !srcRe && !dstWe, "R1 idle after reset",
          {busy, done, srcRe, dstWe}, 0);
    rstN = 1'b1;

    // fixed-key table: R5 R8
    for (int v = 0; v < 8; v++) begin
      int bad = 0;
      for (int i = 0; i < NPIX; i++) srcMem[i] = VEC[v][23:16];
      runImage(1'b1, VEC[v][15:8], 1'b0);
      for (int i = 0; i < NPIX; i++) if (dstMem[i] !== VEC[v][7:0]) bad++;
      check(bad == 0 && wrCount == NPIX, "R5 fixed-key GF product", dstMem[0], VEC[v][7:0]);
      check(busyCnt == 3 * NPIX, "R8 fixed busy length", busyCnt, 3 * NPIX);
    end

    // keyed run on ramp image
    for (int i = 0; i < NPIX; i++) srcMem[i] = 8'(i * 37 + 5);
    runImage(1'b0, 8'hA5, 1'b0);
    checkKeyed(8'hA5, "R2 R4 R5 keyed ciphertext");
    check(!orderBad && wrCount == NPIX, "R6 raster write order", wrCount, NPIX);
    check(busyCnt == 4 * NPIX, "R7 keyed busy length", busyCnt, 4 * NPIX);
    check(riseOk, "R7 busy after start", riseOk, 1);
    check(doneCnt == 1 && doneAt == lastWr + 1, "R9 done one cycle after last write",
          doneAt, lastWr + 1);
    check(!overlap, "R9 busy low with done", overlap, 0);

    // zero seed on uniform image: R3 R4
    for (int i = 0; i < NPIX; i++) srcMem[i] = 8'h5A;
    runImage(1'b0, 8'h00, 1'b0);
    checkKeyed(8'h00, "R3 zero seed replaced");

    // start during run: R10
    for (int i = 0; i < NPIX; i++) srcMem[i] = 8'(255 - i * 11);
    runImage(1'b0, 8'h3C, 1'b1);
    checkKeyed(8'h3C, "R10 mid-run start ignored");
    check(busyCnt == 4 * NPIX && doneCnt == 1, "R10 timing unchanged", busyCnt, 4 * NPIX);

    repeat (2) @(negedge clk);
    check(!busy && !done, "R1 idle after run", {busy, done}, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule